// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block is a watchdog for a system-management controller. Software programs a timeout in ticks, releases the halt bit and must then keep writing the reload register. The count falls by one on each cycle where `tick_en` is high. If software stops reloading, the count reaches its end. The first expiry only raises a timeout flag and, if enabled, an interrupt request to management firmware. A second expiry with no reload in between sets a second-timeout flag and pulses a system-reset request. A no-reboot control bit can veto that pulse, and a board strap can hold that bit at one.

The second-timeout flag and a boot flag are only cleared by the power-on reset `por`. They keep their value through the warm reset `warm_rst`, so software can tell after a restart that the watchdog caused it. All status flags are write-one-to-clear.

Registers are 16-bit words on a byte-addressed synchronous bus with two byte lanes. Read data is registered and valid one cycle after `bus_rd`.
- Timer value at 0x0: a 6-bit field, or 10-bit when `WIDE=1`.
- Reload at 0x2: reads return the live count.
- Control at 0x4: bit0 halt, bit1 interrupt enable, bit2 no-reboot.
- First status at 0x6: bit0 timeout.
- Second status at 0x8: bit1 second-timeout, bit2 boot.

Top module: `sys_wdt`

## Requirements
- R1: After `por`: control reads 0x0005 (halted, no-reboot set), the reload register reads the initial count 4, second status reads 0x0004 (boot flag set), and `smi_req` and `sys_rst_req` are low.
- R2: While control bit0 (halt) is 1 the count does not change on ticks. With halt at 0 the count drops by one per tick.
- R3: A write to 0x2 with byte lane 0 enabled and any of wdata bits 4:0 nonzero loads the count from the timer value. A write whose bits 4:0 are all zero leaves the count unchanged.
- R4: A write to the timer value does not alter the running count. The field is 6 bits wide (10 with `WIDE=1`), a field value below 2 is stored as 2, bits above the field read as 0, and disabled byte lanes keep their old bits.
- R5: A first expiry sets bit0 of 0x6. `smi_req` is high while that flag and control bit1 are both set, and low whenever control bit1 is 0.
- R6: An expiry with no reload since the previous expiry sets bit1 of 0x8 and drives `sys_rst_req` high for exactly 4 cycles. A reload between the two expiries makes the next expiry count as a first one again.
- R7: `sys_rst_req` does not pulse again while bit1 of 0x8 is still set. After software clears that bit, the next expiry pulses again.
- R8: When control bit2 (no-reboot) reads 1, a second expiry still sets bit1 of 0x8 but gives no reset pulse. With `strap_noreboot` high, writing 0 to bit2 still reads back 1.
- R9: Status bits clear only when a 1 is written to them; writing 0 has no effect. A write of 0x6 to 0x8 clears only the second-timeout bit and leaves the boot bit set.
- R10: `warm_rst` returns control, timer value, count and the timeout flag to their reset values but keeps bits 1 and 2 of 0x8. Only `por` clears bit1 and sets bit2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears everything |
| warm_rst | input | 1 | Warm reset, synchronous, active high; spares the persistent flags |
| tick_en | input | 1 | Count enable, one tick per high cycle |
| strap_noreboot | input | 1 | Board strap forcing the no-reboot bit to 1 |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_rdata | output | 16 | Registered read data |
| smi_req | output | 1 | Management interrupt request (level) |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
A stuck or wrong count shows up within one tick as a wrong value read from the reload register. A first-expiry tracker that is lost or never cleared shows up at the next expiry: either a reset pulse where only an interrupt was due, or a missing pulse. A broken pulse counter shows as a wrong number of high cycles on `sys_rst_req`, or as a second pulse while the second-timeout flag is still set. Wrong persistence of flags is exposed by the first status read after a warm reset.

// File: rtl/sys_wdt_pkg.sv
package sys_wdt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_TVAL = 4'h0;
  localparam logic [ADDR_W-1:0] A_RLD  = 4'h2;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'h4;
  localparam logic [ADDR_W-1:0] A_STS1 = 4'h6;
  localparam logic [ADDR_W-1:0] A_STS2 = 4'h8;

  localparam int CB_HALT  = 0;
  localparam int CB_SMIEN = 1;
  localparam int CB_NORB  = 2;
  localparam int SB_TO     = 0;
  localparam int SB_SECOND = 1;
  localparam int SB_BOOT   = 2;
  localparam int RLD_TRIG_W = 5;

  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] new_v,
                                                   input logic [1:0] be);
    return {be[1] ? new_v[15:8] : old_v[15:8], be[0] ? new_v[7:0] : old_v[7:0]};
  endfunction
endpackage

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int CW = 6,
  parameter logic [CW-1:0] INIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          expire
);
  localparam logic [CW-1:0] LAST = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= INIT;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        count <= load_val;
      end else if (run && tick) begin
        if (count == LAST) begin
          count  <= load_val;
          expire <= 1'b1;
        end else begin
          count <= count - CW'(1);
        end
      end
    end
  end

  // R2: halted and not loaded means the count is frozen
  p_halt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count));

  // R4: the clamp keeps every loaded value at 2 or more, so zero is never reached
  p_count_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    count != '0);
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage #(
  parameter int PULSE = 4
) (
  input  logic clk,
  input  logic por,
  input  logic warm,
  input  logic expire,
  input  logic rearm,
  input  logic smi_en,
  input  logic no_reboot,
  input  logic clr_to,
  input  logic clr_second,
  input  logic clr_boot,
  output logic sts_to,
  output logic sts_second,
  output logic sts_boot,
  output logic smi_req,
  output logic rst_req
);
  localparam int PW = $clog2(PULSE + 1);

  logic          first_seen;
  logic [PW-1:0] pulse_cnt;
  logic          second_evt;
  logic          start_pulse;

  assign second_evt  = expire && first_seen;
  assign start_pulse = second_evt && !no_reboot && !sts_second;

  always_ff @(posedge clk) begin
    if (por || warm) begin
      first_seen <= 1'b0;
      sts_to     <= 1'b0;
      smi_req    <= 1'b0;
    end else begin
      if (rearm)       first_seen <= 1'b0;
      else if (expire) first_seen <= 1'b1;
      if (expire && !first_seen) sts_to <= 1'b1;
      else if (clr_to)           sts_to <= 1'b0;
      smi_req <= sts_to && smi_en;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      sts_second <= 1'b0;
      sts_boot   <= 1'b1;
      pulse_cnt  <= '0;
      rst_req    <= 1'b0;
    end else begin
      if (second_evt)      sts_second <= 1'b1;
      else if (clr_second) sts_second <= 1'b0;
      if (clr_boot) sts_boot <= 1'b0;
      if (start_pulse) begin
        rst_req   <= 1'b1;
        pulse_cnt <= PW'(PULSE - 1);
      end else if (pulse_cnt != '0) begin
        pulse_cnt <= pulse_cnt - PW'(1);
      end else begin
        rst_req <= 1'b0;
      end
    end
  end

  // R8: a vetoed reset never starts a pulse
  p_veto_r8: assert property (@(posedge clk) disable iff (por)
    (no_reboot && !rst_req) |=> !rst_req);

  // R7: a pulse only begins while the second-timeout flag was clear
  p_no_reassert_r7: assert property (@(posedge clk) disable iff (por)
    $rose(rst_req) |-> $past(!sts_second));

  // R5: the interrupt stays low whenever its enable is low
  p_smi_gated_r5: assert property (@(posedge clk) disable iff (por || warm)
    !smi_en |=> !smi_req);
endmodule

// File: rtl/sys_wdt.sv
module sys_wdt
  import sys_wdt_pkg::*;
#(
  parameter bit WIDE      = 1'b0,
  parameter int TVAL_INIT = 4,
  parameter int PULSE     = 4
) (
  input  logic        clk,
  input  logic        por,
  input  logic        warm_rst,
  input  logic        tick_en,
  input  logic        strap_noreboot,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic [1:0]  bus_be,
  output logic [15:0] bus_rdata,
  output logic        smi_req,
  output logic        sys_rst_req
);
  localparam int TW = WIDE ? 10 : 6;
  localparam logic [TW-1:0] TV_MIN  = TW'(2);
  localparam logic [TW-1:0] TV_INIT = TW'(TVAL_INIT);

  logic          any_rst;
  logic [TW-1:0] tval;
  logic          halt, smi_en, norb;
  logic          norb_eff;
  logic [TW-1:0] count;
  logic          expire;
  logic          reload_hit;
  logic [15:0]   w1c_bits, tv_merged, ctrl_merged, ctrl_view;
  logic [TW-1:0] tv_field;
  logic          sts_to, sts_second, sts_boot;
  logic          wr_sts1, wr_sts2;
  logic          unused_bits;

  assign any_rst     = por || warm_rst;
  assign norb_eff    = norb || strap_noreboot;
  assign ctrl_view   = {13'd0, norb_eff, smi_en, halt};
  assign tv_merged   = lane_merge(16'(tval), bus_wdata, bus_be);
  assign ctrl_merged = lane_merge(ctrl_view, bus_wdata, bus_be);
  assign tv_field    = tv_merged[TW-1:0];
  assign w1c_bits    = bus_wdata & {{8{bus_be[1]}}, {8{bus_be[0]}}};
  assign reload_hit  = bus_wr && (bus_addr == A_RLD) && bus_be[0] &&
                       (|bus_wdata[RLD_TRIG_W-1:0]);
  assign wr_sts1     = bus_wr && (bus_addr == A_STS1);
  assign wr_sts2     = bus_wr && (bus_addr == A_STS2);
  assign unused_bits = ^{tv_merged, ctrl_merged[15:3], w1c_bits[15:3]};

  always_ff @(posedge clk) begin
    if (any_rst) begin
      tval   <= TV_INIT;
      halt   <= 1'b1;
      smi_en <= 1'b0;
      norb   <= 1'b1;
    end else if (bus_wr) begin
      if (bus_addr == A_TVAL)
        tval <= (tv_field < TV_MIN) ? TV_MIN : tv_field;
      if (bus_addr == A_CTRL) begin
        halt   <= ctrl_merged[CB_HALT];
        smi_en <= ctrl_merged[CB_SMIEN];
        norb   <= ctrl_merged[CB_NORB] | strap_noreboot;
      end
    end
  end

  wdt_down_cnt #(.CW(TW), .INIT(TV_INIT)) u_cnt (
    .clk      (clk),
    .rst      (any_rst),
    .run      (!halt),
    .tick     (tick_en),
    .load     (reload_hit),
    .load_val (tval),
    .count    (count),
    .expire   (expire)
  );

  wdt_stage #(.PULSE(PULSE)) u_stage (
    .clk        (clk),
    .por        (por),
    .warm       (warm_rst),
    .expire     (expire),
    .rearm      (reload_hit),
    .smi_en     (smi_en),
    .no_reboot  (norb_eff),
    .clr_to     (wr_sts1 && w1c_bits[SB_TO]),
    .clr_second (wr_sts2 && w1c_bits[SB_SECOND]),
    .clr_boot   (wr_sts2 && w1c_bits[SB_BOOT] && !w1c_bits[SB_SECOND]),
    .sts_to     (sts_to),
    .sts_second (sts_second),
    .sts_boot   (sts_boot),
    .smi_req    (smi_req),
    .rst_req    (sys_rst_req)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_TVAL:  bus_rdata <= 16'(tval);
        A_RLD:   bus_rdata <= 16'(count);
        A_CTRL:  bus_rdata <= ctrl_view;
        A_STS1:  bus_rdata <= {15'd0, sts_to};
        A_STS2:  bus_rdata <= {13'd0, sts_boot, sts_second, 1'b0};
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/sys_wdt_test.sv
module sys_wdt_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {write data, byte enables, expected timer value readback}
  localparam logic [33:0] TV_VEC [NVEC] = '{
    {16'h0000, 2'b11, 16'h0002},
    {16'h0001, 2'b11, 16'h0002},
    {16'h0025, 2'b11, 16'h0025},
    {16'hFFFF, 2'b11, 16'h003F},
    {16'h0040, 2'b11, 16'h0002},
    {16'h0011, 2'b10, 16'h0002},
    {16'h0002, 2'b11, 16'h0002}
  };

  logic        clk = 1'b0;
  logic        por = 1'b1, warm_rst = 1'b0, tick_en = 1'b0, strap_noreboot = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_rdata;
  logic        smi_req, sys_rst_req;

  int checks = 0;
  int fails  = 0;
  int rst_hi = 0;
  int rst_rises = 0;
  logic rst_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_wdt uut (
    .clk(clk), .por(por), .warm_rst(warm_rst), .tick_en(tick_en),
    .strap_noreboot(strap_noreboot), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .smi_req(smi_req), .sys_rst_req(sys_rst_req)
  );

  always @(negedge clk) begin
    if (sys_rst_req) rst_hi++;
    if (sys_rst_req && !rst_prev) rst_rises++;
    rst_prev = sys_rst_req;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    summary();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    por = 1'b0;
    @(negedge clk);
    check("R1 sys_rst_req", {15'd0, sys_rst_req}, 16'h0000);
    check("R1 smi_req", {15'd0, smi_req}, 16'h0000);
    rd(4'h4, d); check("R1 control", d, 16'h0005);
    rd(4'h2, d); check("R1 count", d, 16'h0004);
    rd(4'h8, d); check("R1 status2", d, 16'h0004);

    ticks(5);
    rd(4'h2, d); check("R2 halted count", d, 16'h0004);

    for (int i = 0; i < NVEC; i++) begin
      wr(4'h0, TV_VEC[i][33:18], TV_VEC[i][17:16]);
      rd(4'h0, d); check($sformatf("R4 tval vector %0d", i), d, TV_VEC[i][15:0]);
    end

    wr(4'h0, 16'h0003, 2'b11);
    rd(4'h2, d); check("R4 running count kept", d, 16'h0004);
    wr(4'h2, 16'h0020, 2'b11);
    rd(4'h2, d); check("R3 zero trigger ignored", d, 16'h0004);
    wr(4'h2, 16'h0001, 2'b11);
    rd(4'h2, d); check("R3 reload", d, 16'h0003);

    wr(4'h4, 16'h0002, 2'b11);
    ticks(1);
    rd(4'h2, d); check("R2 decrement", d, 16'h0002);
    ticks(2);
    rd(4'h6, d); check("R5 first timeout flag", d, 16'h0001);
    check("R5 smi raised", {15'd0, smi_req}, 16'h0001);
    rd(4'h8, d); check("R6 no second on first", d, 16'h0004);
    rd(4'h2, d); check("R6 count restarted", d, 16'h0003);
    check("R6 no pulse yet", 16'(rst_hi), 16'd0);

    wr(4'h6, 16'h0000, 2'b11);
    rd(4'h6, d); check("R9 write zero ignored", d, 16'h0001);
    wr(4'h6, 16'h0001, 2'b11);
    rd(4'h6, d); check("R9 w1c timeout", d, 16'h0000);
    check("R5 smi dropped", {15'd0, smi_req}, 16'h0000);

    wr(4'h2, 16'h0001, 2'b11);
    ticks(3);
    rd(4'h8, d); check("R6 reload rearms stage", d, 16'h0004);
    check("R6 no pulse after rearm", 16'(rst_hi), 16'd0);

    ticks(3);
    rd(4'h8, d); check("R6 second flag", d, 16'h0006);
    check("R6 pulse length", 16'(rst_hi), 16'd4);

    ticks(3);
    check("R7 no reassert", 16'(rst_rises), 16'd1);

    wr(4'h8, 16'h0006, 2'b11);
    rd(4'h8, d); check("R9 both bits clear only second", d, 16'h0004);
    wr(4'h8, 16'h0004, 2'b11);
    rd(4'h8, d); check("R9 boot cleared", d, 16'h0000);

    ticks(3);
    check("R7 pulse after clear", 16'(rst_rises), 16'd2);
    check("R6 second pulse length", 16'(rst_hi), 16'd8);

    @(negedge clk); warm_rst = 1'b1;
    repeat (2) @(negedge clk); warm_rst = 1'b0;
    rd(4'h8, d); check("R10 second survives warm", d, 16'h0002);
    rd(4'h4, d); check("R10 control reset", d, 16'h0005);
    rd(4'h6, d); check("R10 timeout flag reset", d, 16'h0000);
    rd(4'h0, d); check("R10 tval reset", d, 16'h0004);

    strap_noreboot = 1'b1;
    wr(4'h4, 16'h0000, 2'b11);
    rd(4'h4, d); check("R8 strap forces no-reboot", d, 16'h0004);
    wr(4'h8, 16'h0002, 2'b11);
    ticks(8);
    rd(4'h8, d); check("R8 second flag under veto", d, 16'h0002);
    check("R8 no pulse under veto", 16'(rst_rises), 16'd2);
    rd(4'h6, d); check("R5 flag set", d, 16'h0001);
    check("R5 smi off when disabled", {15'd0, smi_req}, 16'h0000);

    strap_noreboot = 1'b0;
    wr(4'h4, 16'h0001, 2'b11);
    rd(4'h4, d); check("R8 no-reboot cleared", d, 16'h0001);

    @(negedge clk); por = 1'b1;
    repeat (2) @(negedge clk); por = 1'b0;
    rd(4'h8, d); check("R10 por clears second sets boot", d, 16'h0004);
    check("R1 no reset request after por", {15'd0, sys_rst_req}, 16'h0000);

    summary();
  end
endmodule